// File: doc/BRIEF.md
# Clocked Serial Receiver with Live Word Length

This block receives a serial bit stream that is clocked by an external shift clock. The shift clock and data are sampled in the system clock domain. Each rising edge of the shift clock moves one data bit into a 32-bit shift register. A programmable word length sets how many shifts pass before the shift register is copied into a result register and a ready flag is raised. The shift register is always 32 bits wide, whatever length is programmed.

The length register can be rewritten while reception is running. Such a write does not clear the shift register and does not reset the bit counter. It only moves the point at which the next capture fires. Software can therefore realign word boundaries on a stream that is already running, for example by lengthening one word to absorb a known number of leading junk bits. New bits enter at bit 31. After a word of N bits, the newest N bits occupy the top of the result and the lower bits still hold older data, which the reader must mask off.

Top module: `srx_live_len_rx`

## Requirements
- R1: After reset the result word is 0, the ready flag is low, the bit counter is 0 and the programmed length is 32.
- R2: Each rising edge of `rx_sclk`, seen through a two-flop synchronizer while `rx_en` is high, shifts `rx_sdata` into bit 31 of the 32-bit shift register and moves every older bit one place toward bit 0. A falling edge, or a level held high, causes no shift.
- R3: When the count of shifts since the last capture reaches the effective length, on that same shift the result gets the shift register value that includes the new bit, the ready flag is set and the counter restarts at 0. The shift register is not cleared, so the bits below the newest word are older stream bits.
- R4: A length write, through `len_we` with `len_wdata`, changes neither the shift register nor the bit counter. It only changes when the next capture fires.
- R5: If the newly written length is less than or equal to the number of shifts already counted, the capture fires on the next shift.
- R6: A written length value of 0, or any value above 32, gives an effective length of 32. The values 1 to 32 are used as written.
- R7: While `rx_en` is low, shift clock edges are ignored. The shift register, the counter, the result and the ready flag keep their values, and reception carries on from that state once `rx_en` is high again.
- R8: A one-cycle `rd_ack` pulse clears the ready flag. The result word holds its value until the next capture. A capture overwrites the result even if the ready flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable; when low, the shift clock is ignored |
| rx_sclk | input | 1 | External shift clock, asynchronous to `clk` |
| rx_sdata | input | 1 | Serial data, sampled on the rising edge of the shift clock |
| len_we | input | 1 | Write strobe for the word length |
| len_wdata | input | 6 | New word length; 0 or values above 32 mean 32 |
| rd_ack | input | 1 | Read acknowledge; clears the ready flag |
| rx_word | output | 32 | Captured shift register contents |
| rx_ready | output | 1 | A new word has been captured and not yet acknowledged |

## Verification
The bench rewrites the length partway through a word, both to a longer value and to a value below the current count. A design that cleared the shifter or the counter on such a write would capture late and with the wrong bits. A design that compared for equality only would never fire after a downward rewrite. The bench also checks that the low bits of a short word keep the stale data, which a design that zeroed its shift register on capture would lose. It checks that pulses sent while the receiver is disabled leave no trace, and that a capture overwrites a word that was never acknowledged. Random traffic mixes all of these with out-of-range length values, where a design that did not clamp the length would either capture at once or never capture.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_DEF_SHIFT_W = 32;

  // Map a written length to the one actually used: 0 or too big means full width.
  function automatic int unsigned srx_clamp_len(int unsigned v, int unsigned w);
    return ((v == 0) || (v > w)) ? w : v;
  endfunction
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic rise_o,
  output logic bit_o
);
  logic [2:0] sclk_q;
  logic [1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      data_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_in};
      data_q <= {data_q[0], sdata_in};
    end
  end

  // The data bit travels through the same two stages as the clock, so they stay aligned.
  assign rise_o = sclk_q[1] & ~sclk_q[2];
  assign bit_o  = data_q[1];

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int unsigned SHIFT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               din,
  output logic [SHIFT_W-1:0] sh_q,
  output logic [SHIFT_W-1:0] sh_nxt
);
  // Newest bit enters at the top; older bits move toward bit 0.
  assign sh_nxt = {din, sh_q[SHIFT_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (shift_en) sh_q <= sh_nxt;
  end

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sh_q)); // R4
endmodule

// File: rtl/srx_frame_ctl.sv
module srx_frame_ctl
  import srx_pkg::*;
#(
  parameter int unsigned SHIFT_W = 32,
  parameter int unsigned LEN_W   = $clog2(SHIFT_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [SHIFT_W-1:0] sh_nxt,
  input  logic               len_we,
  input  logic [LEN_W-1:0]   len_wdata,
  input  logic               rd_ack,
  output logic [SHIFT_W-1:0] word_q,
  output logic               rdy_q
);
  localparam int unsigned CNT_W = $clog2(SHIFT_W);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_eff;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_inc;
  logic             cap;

  always_comb begin
    len_eff = LEN_W'(srx_clamp_len(int'(len_q), SHIFT_W));
    cnt_inc = LEN_W'(cnt_q) + LEN_W'(1);
    // ">=" lets a length lowered below the running count fire on the next shift.
    cap     = shift_en && (cnt_inc >= len_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(SHIFT_W);
    end else if (len_we) begin
      len_q <= len_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cap) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      cnt_q <= CNT_W'(cnt_inc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (cap) word_q <= sh_nxt;
      if (cap)         rdy_q <= 1'b1;
      else if (rd_ack) rdy_q <= 1'b0;
    end
  end

  AST_LEN_WR_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    (len_we && !shift_en) |=> $stable(cnt_q)); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(word_q)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !cap) |=> !rdy_q); // R8
  AST_RDY_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(shift_en)); // R3
endmodule

// File: rtl/srx_live_len_rx.sv
module srx_live_len_rx
  import srx_pkg::*;
#(
  parameter int unsigned SHIFT_W = SRX_DEF_SHIFT_W,
  parameter int unsigned LEN_W   = $clog2(SHIFT_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_en,
  input  logic               rx_sclk,
  input  logic               rx_sdata,
  input  logic               len_we,
  input  logic [LEN_W-1:0]   len_wdata,
  input  logic               rd_ack,
  output logic [SHIFT_W-1:0] rx_word,
  output logic               rx_ready
);
  logic               rise;
  logic               sbit;
  logic               shift_en;
  logic [SHIFT_W-1:0] sh_q;
  logic [SHIFT_W-1:0] sh_nxt;

  srx_edge_sync sync_i (
    .clk      (clk),
    .rst      (rst),
    .sclk_in  (rx_sclk),
    .sdata_in (rx_sdata),
    .rise_o   (rise),
    .bit_o    (sbit)
  );

  assign shift_en = rise & rx_en;

  srx_shifter #(.SHIFT_W(SHIFT_W)) shreg_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (sbit),
    .sh_q     (sh_q),
    .sh_nxt   (sh_nxt)
  );

  srx_frame_ctl #(.SHIFT_W(SHIFT_W), .LEN_W(LEN_W)) ctl_i (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .sh_nxt    (sh_nxt),
    .len_we    (len_we),
    .len_wdata (len_wdata),
    .rd_ack    (rd_ack),
    .word_q    (rx_word),
    .rdy_q     (rx_ready)
  );

  AST_DISABLED_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> $stable(rx_word)); // R7
  AST_DISABLED_NO_READY: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !$rose(rx_ready)); // R7
endmodule

// File: tb/srx_live_len_rx_tb_top.sv
`timescale 1ns/1ps
module srx_live_len_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b1;
  logic        rx_sclk = 1'b0;
  logic        rx_sdata = 1'b0;
  logic        len_we = 1'b0;
  logic [5:0]  len_wdata = '0;
  logic        rd_ack = 1'b0;
  logic [31:0] rx_word;
  logic        rx_ready;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] m_sh;
  logic [31:0] m_word;
  logic        m_rdy;
  int unsigned m_cnt;
  int unsigned m_len;
  bit          m_en;

  always #4 clk = ~clk;

  srx_live_len_rx dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_sclk(rx_sclk), .rx_sdata(rx_sdata),
    .len_we(len_we), .len_wdata(len_wdata), .rd_ack(rd_ack),
    .rx_word(rx_word), .rx_ready(rx_ready)
  );

  function automatic int unsigned eff_len(int unsigned v);
    return ((v == 0) || (v > 32)) ? 32 : v;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req);
    total++;
    if (rx_word !== m_word) begin
      bad++;
      $display("FAIL %s word actual=%h expected=%h", req, rx_word, m_word);
    end
    total++;
    if (rx_ready !== m_rdy) begin
      bad++;
      $display("FAIL %s ready actual=%b expected=%b", req, rx_ready, m_rdy);
    end
  endtask

  task automatic send_bit(logic b, string req);
    rx_sdata = b;
    tick(2);
    rx_sclk = 1'b1;
    tick(4);
    rx_sclk = 1'b0;
    tick(3);
    if (m_en) begin
      m_sh = {b, m_sh[31:1]};
      m_cnt++;
      if (m_cnt >= eff_len(m_len)) begin
        m_word = m_sh;
        m_rdy  = 1'b1;
        m_cnt  = 0;
      end
    end
    check(req);
  endtask

  task automatic send_bits(int n, logic [31:0] pat, string req);
    for (int i = 0; i < n; i++) send_bit(pat[i % 32], req);
  endtask

  task automatic write_len(logic [5:0] v, string req);
    len_we = 1'b1;
    len_wdata = v;
    tick(1);
    len_we = 1'b0;
    tick(1);
    m_len = v;
    check(req);
  endtask

  task automatic do_ack(string req);
    rd_ack = 1'b1;
    tick(1);
    rd_ack = 1'b0;
    tick(1);
    m_rdy = 1'b0;
    check(req);
  endtask

  task automatic set_en(bit e);
    rx_en = e;
    m_en = e;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = $urandom(32'd4242);
    m_sh = '0; m_word = '0; m_rdy = 1'b0; m_cnt = 0; m_len = 32; m_en = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R1 reset state");

    // Default length 32: ready only after the 32nd bit
    send_bits(32, 32'hC3A5_0F96, "R1 R2 R3 default length");
    do_ack("R8 ack clears ready");

    // Short word keeps stale low bits
    write_len(6'd8, "R4 length write");
    send_bits(8, 32'h0000_005A, "R3 short word stale bits");
    // No ack: overwrite while ready still high
    send_bits(8, 32'h0000_00E1, "R8 overwrite unacknowledged");
    do_ack("R8 ack");

    // Lengthen mid-word: 16 then 20, counter carries on
    write_len(6'd16, "R4 set 16");
    send_bits(10, 32'h0000_02B7, "R4 first part");
    write_len(6'd20, "R4 lengthen mid-word");
    send_bits(10, 32'h0000_0351, "R4 capture at 20");
    do_ack("R8 ack");

    // Lower below count: fires on next shift
    write_len(6'd16, "R5 set 16");
    send_bits(12, 32'h0000_0A6C, "R5 first part");
    write_len(6'd8, "R5 lower below count");
    send_bit(1'b1, "R5 capture on next shift");
    do_ack("R8 ack");

    // Clamp: 0 and 40 both mean 32
    write_len(6'd0, "R6 length zero");
    send_bits(32, 32'h1234_5678, "R6 zero means 32");
    do_ack("R8 ack");
    write_len(6'd40, "R6 length 40");
    send_bits(32, 32'h9ABC_DEF0, "R6 forty means 32");
    do_ack("R8 ack");

    // Disable ignores edges
    write_len(6'd4, "R7 set 4");
    send_bits(2, 32'h3, "R7 before disable");
    set_en(1'b0);
    send_bits(6, 32'h15, "R7 disabled pulses ignored");
    set_en(1'b1);
    send_bits(2, 32'h2, "R7 resume completes word");

    // Random traffic
    for (int it = 0; it < 400; it++) begin
      r = $urandom % 100;
      if (r < 70)      send_bit(1'($urandom), "R2 R3 random bit");
      else if (r < 82) write_len(6'($urandom % 41), "R4 R5 R6 random length");
      else if (r < 92) do_ack("R8 random ack");
      else             set_en(($urandom % 4) != 0);
    end
    if (seed == 0) tick(1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule